// File: doc/BRIEF.md
# ADC Multiplexer Frame Sequencer

This block paces a multichannel ADC front end from a slow clock enable that is derived from a 32 kHz source. Each frame visits a programmable number of channels in ascending order, starting at channel 0. The filter-length selector sets each conversion to two slow ticks (short filter) or three slow ticks (long filter). After the last conversion comes one extra settle tick, which lets the reference voltage recover before the next frame begins. The block runs entirely in the fast clock domain and acts only on cycles where the slow enable is high. The converter itself is not modelled: the block generates the end-of-conversion events.

When the channel 0 conversion of a frame begins, the block emits a one-cycle compute-start strobe. When a conversion completes, it emits a write strobe together with the data-memory address of that channel. A frame-sync pulse marks entry into the settle tick. A pass counter counts compute starts, and a transfer-busy flag goes high for one whole pass out of every presample-count × sum-cycle-count passes.

All configuration is captured at frame boundaries. A conversion count of zero stops the sequencer once the current frame has finished.

Top module: `adc_frame_seq`

## Requirements
- R1: While the synchronous reset is high, all strobes are low, `xfer_busy` is 0, `cur_chan` is 0 and `in_settle` is 0.
- R2: When `mux_count` is 0 at a frame boundary, the sequencer goes idle. While idle it produces no `ce_start`, `wr_en` or `frame_sync`.
- R3: Successive conversion completions are exactly 2 slow ticks apart when `long_filter`=0 and 3 slow ticks apart when `long_filter`=1. The first completion of a frame comes the same number of ticks after its `ce_start`.
- R4: Within a run of consecutive frames, successive `ce_start` pulses are 1 + N×C slow ticks apart. Here N is the latched `mux_count` and C is 2 or 3.
- R5: Each frame issues exactly N `wr_en` pulses, and their `wr_addr` values are 0, 1, …, N-1 in that order.
- R6: `frame_sync` pulses together with the write of channel N-1, and `in_settle` is 1 at that point. The settle state lasts exactly one slow tick.
- R7: `ce_start` is issued when channel 0 starts converting; at that point `cur_chan` is 0 and `in_settle` is 0.
- R8: `xfer_busy` changes only together with `ce_start`. It is 1 during the k-th pass, counted from reset, exactly when k is a multiple of P×S, where P is `presamps` and S is `sum_cycles`. A product of 0 counts as 1.
- R9: Changes to `mux_count`, `long_filter`, `presamps` or `sum_cycles` made during a frame do not affect that frame; they take effect at the next `ce_start`.
- R10: Every strobe is one fast clock wide and appears only in the cycle after `slow_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_en | input | 1 | One-cycle slow tick enable |
| mux_count | input | CH_W (4) | Conversions per frame, 0 = stop |
| long_filter | input | 1 | 1 = three ticks per conversion, 0 = two |
| presamps | input | PS_W (8) | Presample count P |
| sum_cycles | input | SC_W (8) | Sum-cycle count S |
| ce_start | output | 1 | Compute pass start strobe |
| frame_sync | output | 1 | Settle-entry pulse |
| wr_en | output | 1 | Conversion-result write strobe |
| wr_addr | output | CH_W (4) | Data-memory address of the completed channel |
| xfer_busy | output | 1 | High for one pass every P×S passes |
| cur_chan | output | CH_W (4) | Channel currently converting |
| in_settle | output | 1 | Sequencer is in the settle tick |

## Verification
Corruption of the phase counter would show up as an uneven spacing of `wr_en` relative to `ce_start`, and the bench detects that at the next completion, within three slow ticks. A wrong channel index changes `wr_addr` or the number of writes per frame, which is detected at the next write or at the next frame start. If the pass counter slips, the pass on which `xfer_busy` rises moves. The bench compares every start against its own count of passes, so such a slip is detected at the first pass where the busy flag differs.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_CONV   = 2'd1,
    SQ_SETTLE = 2'd2
  } seq_state_e;

  // slow ticks per conversion for the selected filter length
  function automatic logic [1:0] conv_ticks(input logic long_f);
    return long_f ? 2'd3 : 2'd2;
  endfunction

  // slow ticks per frame: conversions plus one settle tick
  function automatic int unsigned frame_ticks(input int unsigned n, input logic long_f);
    return 1 + n * 32'(conv_ticks(long_f));
  endfunction

  // passes per transfer interval; an empty product counts as one
  function automatic int unsigned xfer_period(input int unsigned p, input int unsigned s);
    int unsigned prod;
    prod = p * s;
    return (prod == 0) ? 1 : prod;
  endfunction

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [CH_W-1:0] mux_n,
  input  logic            long_f,
  output logic            start_evt,
  output logic            ce_start,
  output logic            frame_sync,
  output logic            wr_en,
  output logic [CH_W-1:0] wr_addr,
  output logic [CH_W-1:0] cur_chan,
  output logic            in_settle
);

  localparam int FRM_W = CH_W + 3;

  seq_state_e      state;
  logic [CH_W-1:0] chan;
  logic [CH_W-1:0] n_lat;
  logic            long_lat;
  logic [1:0]      phase;
  logic [1:0]      per;
  logic            last_phase;
  logic            last_chan;
  logic            conv_end;
  logic [FRM_W-1:0] frm_cnt;
  logic            chained;

  assign per        = conv_ticks(long_lat);
  assign last_phase = (phase == per - 2'd1);
  assign last_chan  = (chan == n_lat - CH_W'(1));
  assign start_evt  = tick && (mux_n != '0) &&
                      ((state == SQ_IDLE) || (state == SQ_SETTLE));
  assign conv_end   = tick && (state == SQ_CONV) && last_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      chan       <= '0;
      phase      <= '0;
      n_lat      <= '0;
      long_lat   <= 1'b0;
      ce_start   <= 1'b0;
      frame_sync <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
    end else begin
      ce_start   <= 1'b0;
      frame_sync <= 1'b0;
      wr_en      <= 1'b0;
      if (start_evt) begin
        state    <= SQ_CONV;
        chan     <= '0;
        phase    <= '0;
        n_lat    <= mux_n;
        long_lat <= long_f;
        ce_start <= 1'b1;
      end else if (tick) begin
        case (state)
          SQ_SETTLE: state <= SQ_IDLE;
          SQ_CONV: begin
            if (conv_end) begin
              wr_en   <= 1'b1;
              wr_addr <= chan;
              phase   <= '0;
              if (last_chan) begin
                state      <= SQ_SETTLE;
                frame_sync <= 1'b1;
                chan       <= '0;
              end else begin
                chan <= chan + CH_W'(1);
              end
            end else begin
              phase <= phase + 2'd1;
            end
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end

  // frame tick counter, used only to guard the frame length
  always_ff @(posedge clk) begin
    if (rst) begin
      frm_cnt <= '0;
      chained <= 1'b0;
    end else if (start_evt) begin
      frm_cnt <= '0;
      chained <= 1'b1;
    end else if (tick) begin
      frm_cnt <= frm_cnt + FRM_W'(1);
      if (state == SQ_SETTLE) chained <= 1'b0;
    end
  end

  assign cur_chan  = chan;
  assign in_settle = (state == SQ_SETTLE);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE) |-> (!wr_en && !ce_start && !frame_sync));
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_CONV) |-> (phase < per));
  a_r4_frame_len: assert property (@(posedge clk) disable iff (rst)
    (start_evt && chained) |-> (frm_cnt == FRM_W'(frame_ticks(32'(n_lat), long_lat) - 1)));
  a_r5_addr_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr < n_lat));
  a_r6_settle_single: assert property (@(posedge clk) disable iff (rst)
    ((state == SQ_SETTLE) && tick) |=> (state != SQ_SETTLE));
  a_r7_start_chan0: assert property (@(posedge clk) disable iff (rst)
    ce_start |-> ((chan == '0) && (state == SQ_CONV) && (phase == '0)));
  a_r10_strobe_on_tick: assert property (@(posedge clk) disable iff (rst)
    (wr_en || ce_start || frame_sync) |-> $past(tick));

endmodule

// File: rtl/adc_pass_ctr.sv
module adc_pass_ctr
  import adc_seq_pkg::*;
#(
  parameter int PS_W = 8,
  parameter int SC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_evt,
  input  logic [PS_W-1:0] presamps,
  input  logic [SC_W-1:0] sum_cycles,
  output logic            xfer_busy
);

  localparam int PROD_W = PS_W + SC_W;

  logic [PROD_W-1:0] cnt;
  int unsigned       period;
  logic              wrap;

  assign period = xfer_period(32'(presamps), 32'(sum_cycles));
  assign wrap   = (32'(cnt) >= period - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      xfer_busy <= 1'b0;
    end else if (start_evt) begin
      if (wrap) begin
        cnt       <= '0;
        xfer_busy <= 1'b1;
      end else begin
        cnt       <= cnt + PROD_W'(1);
        xfer_busy <= 1'b0;
      end
    end
  end

  a_r8_busy_only_on_start: assert property (@(posedge clk) disable iff (rst)
    !$past(start_evt) |-> $stable(xfer_busy));
  a_r8_busy_at_wrap: assert property (@(posedge clk) disable iff (rst)
    xfer_busy |-> (cnt == '0));

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 4,
  parameter int PS_W = 8,
  parameter int SC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slow_en,
  input  logic [CH_W-1:0] mux_count,
  input  logic            long_filter,
  input  logic [PS_W-1:0] presamps,
  input  logic [SC_W-1:0] sum_cycles,
  output logic            ce_start,
  output logic            frame_sync,
  output logic            wr_en,
  output logic [CH_W-1:0] wr_addr,
  output logic            xfer_busy,
  output logic [CH_W-1:0] cur_chan,
  output logic            in_settle
);

  logic start_evt;

  adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .tick       (slow_en),
    .mux_n      (mux_count),
    .long_f     (long_filter),
    .start_evt  (start_evt),
    .ce_start   (ce_start),
    .frame_sync (frame_sync),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .cur_chan   (cur_chan),
    .in_settle  (in_settle)
  );

  adc_pass_ctr #(.PS_W(PS_W), .SC_W(SC_W)) u_pass (
    .clk        (clk),
    .rst        (rst),
    .start_evt  (start_evt),
    .presamps   (presamps),
    .sum_cycles (sum_cycles),
    .xfer_busy  (xfer_busy)
  );

  a_r6_sync_with_last: assert property (@(posedge clk) disable iff (rst)
    frame_sync |-> (wr_en && in_settle));
  a_r8_busy_with_start: assert property (@(posedge clk) disable iff (rst)
    $changed(xfer_busy) |-> ce_start);
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!ce_start && !wr_en && !frame_sync && !xfer_busy));

endmodule

// File: tb/test_adc_frame_seq.sv
module test_adc_frame_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slow_en = 1'b0;
  logic [3:0] mux_count = 4'd0;
  logic       long_filter = 1'b0;
  logic [7:0] presamps = 8'd1;
  logic [7:0] sum_cycles = 8'd1;
  logic       ce_start, frame_sync, wr_en, xfer_busy, in_settle;
  logic [3:0] wr_addr, cur_chan;

  always #2 clk = ~clk;  // 250 MHz

  adc_frame_seq i_adc_frame_seq (
    .clk(clk), .rst(rst), .slow_en(slow_en), .mux_count(mux_count),
    .long_filter(long_filter), .presamps(presamps), .sum_cycles(sum_cycles),
    .ce_start(ce_start), .frame_sync(frame_sync), .wr_en(wr_en),
    .wr_addr(wr_addr), .xfer_busy(xfer_busy), .cur_chan(cur_chan),
    .in_settle(in_settle)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {n[3:0], long, p[7:0], s[7:0]}
  localparam int NV = 6;
  localparam logic [20:0] VEC [NV] = '{
    {4'd4,  1'b1, 8'd2, 8'd3},
    {4'd4,  1'b0, 8'd1, 8'd1},
    {4'd1,  1'b0, 8'd3, 8'd2},
    {4'd15, 1'b1, 8'd1, 8'd2},
    {4'd3,  1'b1, 8'd0, 8'd5},
    {4'd2,  1'b0, 8'd4, 8'd1}
  };

  // monitor state
  int tick_idx = 0, div = 0;
  int m_n = 0, m_per = 2, m_start = 0, m_last = 0, wi = 0;
  int passes = 0, period = 1, starts = 0, writes = 0;
  bit m_started = 0;

  always @(negedge clk) begin
    bit tk;
    tk = slow_en;
    if (rst) begin
      m_started = 0; wi = 0; passes = 0; starts = 0; writes = 0;
    end else begin
      if (!tk && (ce_start || wr_en || frame_sync))
        chk(0, "R10 strobe without tick", 1, 0);
      if (ce_start) begin
        starts++;
        if (m_started) begin
          chk(wi == m_n, "R5 R9 writes per frame", wi, m_n);
          chk(tick_idx - m_start == m_n * m_per + 1, "R4 frame length",
              tick_idx - m_start, m_n * m_per + 1);
        end
        chk(cur_chan == 0 && !in_settle, "R7 start on channel 0", int'(cur_chan), 0);
        m_n = int'(mux_count);
        m_per = long_filter ? 3 : 2;
        period = int'(presamps) * int'(sum_cycles);
        if (period == 0) period = 1;
        passes++;
        chk(xfer_busy == ((passes % period) == 0), "R8 transfer busy",
            int'(xfer_busy), int'((passes % period) == 0));
        m_start = tick_idx; m_last = tick_idx; wi = 0; m_started = 1;
      end
      if (wr_en) begin
        writes++;
        chk(int'(wr_addr) == wi, "R5 write address", int'(wr_addr), wi);
        chk(tick_idx - m_last == m_per, "R3 conversion length", tick_idx - m_last, m_per);
        chk(frame_sync == (wi == m_n - 1), "R6 frame sync", int'(frame_sync), int'(wi == m_n - 1));
        chk(in_settle == (wi == m_n - 1), "R6 settle entry", int'(in_settle), int'(wi == m_n - 1));
        m_last = tick_idx;
        wi++;
      end
    end
    // slow tick generator: one clock high every four
    div = (div + 1) % 4;
    slow_en = (div == 0);
    if (slow_en) tick_idx++;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    // R1: reset state while the slow tick keeps running
    mux_count = 4'd3; long_filter = 1'b1;
    repeat (12) @(negedge clk);
    chk(!ce_start && !wr_en && !frame_sync, "R1 strobes in reset", 1, 0);
    chk(!xfer_busy, "R1 xfer_busy in reset", int'(xfer_busy), 0);
    chk(cur_chan == 0 && !in_settle, "R1 channel in reset", int'(cur_chan), 0);

    // table of configurations, 12 frames each
    for (int v = 0; v < NV; v++) begin
      {mux_count, long_filter, presamps, sum_cycles} = VEC[v];
      do_reset();
      while (starts < 12) @(negedge clk);
      chk(starts == 12, "R4 table run", starts, 12);
    end

    // R2: zero count keeps the sequencer idle
    mux_count = 4'd0;
    do_reset();
    repeat (200) @(negedge clk);
    chk(starts == 0 && writes == 0, "R2 idle produces nothing", starts + writes, 0);
    chk(cur_chan == 0 && !in_settle, "R2 idle state", int'(in_settle), 0);

    // R2: zero count applied mid-run stops after the current frame
    mux_count = 4'd2; long_filter = 1'b0; presamps = 8'd1; sum_cycles = 8'd1;
    do_reset();
    while (starts < 1) @(negedge clk);
    mux_count = 4'd0;
    repeat (200) @(negedge clk);
    chk(starts == 1, "R2 stop after frame starts", starts, 1);
    chk(writes == 2, "R2 stop after frame writes", writes, 2);

    // R9: mid-frame configuration change applies at the next start
    mux_count = 4'd4; long_filter = 1'b0; presamps = 8'd2; sum_cycles = 8'd1;
    do_reset();
    while (starts < 1) @(negedge clk);
    repeat (3) @(negedge clk);
    mux_count = 4'd2; long_filter = 1'b1; presamps = 8'd1;
    while (starts < 2) @(negedge clk);
    chk(writes == 4, "R9 first frame kept old count", writes, 4);
    while (starts < 3) @(negedge clk);
    chk(writes == 6, "R9 second frame used new count", writes, 6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule